// File: doc/BRIEF.md
# Three-Counter Performance Monitor

This block counts activity for a processor core. It has one cycle counter and two event counters, all 32 bits wide. A single register port reaches them and a control register. Each event counter picks its source with an 8-bit code. The code can name one strobe from the core's vector of single-cycle event strobes, the external trace-output line, or every clock. Any other code counts nothing.

The counters have no enable of their own. Software stops an event counter by selecting the trace-output code while that line is held low. When a counter wraps past all-ones it raises its overflow flag. The three flags, each gated by its own interrupt enable, share one interrupt line. Software clears flags by writing back the control word it just read. The other control fields then return unchanged, so only the flags that were set get cleared.

A mode state machine holds the global enable and the cycle-prescaler choice. It has four states:

| State | Global enable | Prescaler |
|---|---|---|
| `ST_HALT_FULL` | off | off |
| `ST_HALT_DIV` | off | on |
| `ST_RUN_FULL` | on | off |
| `ST_RUN_DIV` | on | on |

Every write to the control register moves the machine to the state named by the written enable bit (bit 0) and divide bit (bit 3). Without such a write the machine stays where it is.

In `ST_RUN_DIV` a modulo-64 prescaler produces the cycle tick. The prescaler is held at zero in every other state.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, the control register reads 0, all three counters read 0 and `irq` is low.
- R2: While bit 0 (enable) is set and bit 3 (divide) is clear, the cycle counter rises by one on every clock edge. While bit 0 is clear, the cycle counter holds its value.
- R3: When bits 0 and 3 are both set, the cycle counter rises by one once every 64 clocks. The first increment comes on the 64th edge after the enabling write. Bit 3 reads back, and keeps its value while the unit is halted.
- R4: While enabled, an event counter rises on each clock where its selected source is high. Code n below 32 selects `evt_strobe[n]`. Code 0x20 selects `trace_out`. Code 0xFF counts every clock. Any other code never counts.
- R5: An event counter set to code 0x20 holds its value while `trace_out` is low, even if every event strobe is high.
- R6: A write to index 1, 2 or 3 loads that counter with the data. An increment due on the same edge is dropped.
- R7: Writing 1 to control bit 1 clears both event counters. Writing 1 to bit 2 clears the cycle counter. Each of these bits leaves the other counter untouched and reads back as 0.
- R8: A counter that wraps from all-ones to 0 sets its overflow flag: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter.
- R9: Writing 1 to a flag bit clears that flag, and writing 0 leaves it. Writing back a value just read therefore clears exactly the flags that were set. If a wrap happens on the same edge as a clear, the flag stays set.
- R10: `irq` is high exactly when a flag is set and its interrupt enable is also set. The enables are bit 4 (event counter 0), bit 5 (event counter 1) and bit 6 (cycle counter).
- R11: The register index selects the target: 0 is control, 1 the cycle counter, 2 event counter 0, 3 event counter 1. The control register reads back as follows, and all other bits read 0:
  - bits 27:20: event counter 0 code
  - bits 19:12: event counter 1 code
  - bits 10:8: overflow flags
  - bits 6:4: interrupt enables
  - bit 3: divide
  - bit 0: enable

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_idx | input | 2 | Register index: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the indexed register, combinational |
| evt_strobe | input | NUM_EVT | Single-cycle event strobes from the core |
| trace_out | input | 1 | External trace-output line, selected by code 0x20 |
| irq | output | 1 | Shared overflow interrupt |

## Verification
The bench builds the unit with its default parameters: 32-bit counters, 32 event strobes and a prescaler of 64. With these values the prescaled first tick, at the 64th edge, is a short directed wait. Overflow is reached in one or two clocks by preloading a counter with 0xFFFFFFFE or 0xFFFFFFFF. This is also how the bench creates a wrap on the same edge as a flag-clearing write. The event strobes can name every code from 0 to 31, so the bench also reaches the boundary codes 0x20 (trace) and 0x40 (counts nothing).

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int REG_W   = 32;
    localparam int SEL_W   = 8;
    localparam int NUM_SRC = 3;

    // control register bit positions
    localparam int CTL_EN      = 0;
    localparam int CTL_EVRST   = 1;
    localparam int CTL_CYRST   = 2;
    localparam int CTL_DIV     = 3;
    localparam int CTL_IE_LSB  = 4;
    localparam int CTL_OVF_LSB = 8;
    localparam int SEL1_LSB    = 12;
    localparam int SEL0_LSB    = 20;

    // source slots for flags and interrupt enables
    localparam int SRC_EV0 = 0;
    localparam int SRC_EV1 = 1;
    localparam int SRC_CYC = 2;

    // register indices
    localparam logic [1:0] IDX_CTL = 2'd0;
    localparam logic [1:0] IDX_CYC = 2'd1;
    localparam logic [1:0] IDX_EV0 = 2'd2;
    localparam logic [1:0] IDX_EV1 = 2'd3;

    localparam logic [SEL_W-1:0] CODE_TRACE  = 8'h20;
    localparam logic [SEL_W-1:0] CODE_CYCLES = 8'hFF;

    typedef enum logic [1:0] {
        ST_HALT_FULL = 2'd0,
        ST_HALT_DIV  = 2'd1,
        ST_RUN_FULL  = 2'd2,
        ST_RUN_DIV   = 2'd3
    } pmu_mode_e;

endpackage

// File: rtl/pmu_mode_fsm.sv
module pmu_mode_fsm
    import pmu_pkg::*;
#(
    parameter int PRESCALE = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic wr_en,
    input  logic wr_div,
    output logic running,
    output logic div_sel,
    output logic cyc_tick
);

    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

    pmu_mode_e state_q, state_d;
    logic [PW-1:0] pre_q;

    always_comb begin
        state_d = state_q;
        if (ctl_wr) begin
            unique case ({wr_en, wr_div})
                2'b00: state_d = ST_HALT_FULL;
                2'b01: state_d = ST_HALT_DIV;
                2'b10: state_d = ST_RUN_FULL;
                2'b11: state_d = ST_RUN_DIV;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT_FULL;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    pre_q <= '0;
        else if (state_q != ST_RUN_DIV) pre_q <= '0;
        else if (pre_q == PRE_LAST)     pre_q <= '0;
        else                            pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        unique case (state_q)
            ST_HALT_FULL: begin running = 1'b0; div_sel = 1'b0; cyc_tick = 1'b0; end
            ST_HALT_DIV:  begin running = 1'b0; div_sel = 1'b1; cyc_tick = 1'b0; end
            ST_RUN_FULL:  begin running = 1'b1; div_sel = 1'b0; cyc_tick = 1'b1; end
            ST_RUN_DIV:   begin running = 1'b1; div_sel = 1'b1; cyc_tick = (pre_q == PRE_LAST); end
        endcase
    end

endmodule

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel
    import pmu_pkg::*;
#(
    parameter int NUM_EVT = 32
) (
    input  logic [SEL_W-1:0]   code,
    input  logic [NUM_EVT-1:0] strobes,
    input  logic               trace,
    output logic               hit
);

    always_comb begin
        hit = 1'b0;
        if (code == CODE_CYCLES) begin
            hit = 1'b1;
        end else if (code == CODE_TRACE) begin
            hit = trace;
        end else begin
            for (int i = 0; i < NUM_EVT; i++) begin
                if (code == SEL_W'(i)) hit = strobes[i];
            end
        end
    end

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (load)  cnt <= load_val;
        else if (clear) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign wrap = inc && !load && !clear && (cnt == {W{1'b1}});

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NUM_EVT  = 32,
    parameter int PRESCALE = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_idx,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0] evt_strobe,
    input  logic               trace_out,
    output logic               irq
);

    logic                wr_ctl;
    logic                running, div_sel, cyc_tick;
    logic [SEL_W-1:0]    sel_q [2];
    logic [SEL_W-1:0]    sel_wr [2];
    logic [NUM_SRC-1:0]  ie_q, ovf_q, wrap;
    logic [1:0]          hit;
    logic [CNT_W-1:0]    cyc_cnt;
    logic [CNT_W-1:0]    ev_cnt [2];
    logic [REG_W-1:0]    ctl_view;
    logic                unused_wdata;

    assign wr_ctl    = reg_we && (reg_idx == IDX_CTL);
    assign sel_wr[0] = reg_wdata[SEL0_LSB +: SEL_W];
    assign sel_wr[1] = reg_wdata[SEL1_LSB +: SEL_W];
    assign unused_wdata = ^{reg_wdata[REG_W-1:SEL0_LSB+SEL_W], reg_wdata[CTL_OVF_LSB+NUM_SRC],
                            reg_wdata[CTL_IE_LSB+NUM_SRC]};

    pmu_mode_fsm #(.PRESCALE(PRESCALE)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (wr_ctl),
        .wr_en    (reg_wdata[CTL_EN]),
        .wr_div   (reg_wdata[CTL_DIV]),
        .running  (running),
        .div_sel  (div_sel),
        .cyc_tick (cyc_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q[0] <= '0;
            sel_q[1] <= '0;
            ie_q     <= '0;
        end else if (wr_ctl) begin
            sel_q[0] <= sel_wr[0];
            sel_q[1] <= sel_wr[1];
            ie_q     <= reg_wdata[CTL_IE_LSB +: NUM_SRC];
        end
    end

    // a wrap on the same edge as a clearing write keeps the flag set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= '0;
        end else begin
            for (int k = 0; k < NUM_SRC; k++) begin
                if (wrap[k])                                   ovf_q[k] <= 1'b1;
                else if (wr_ctl && reg_wdata[CTL_OVF_LSB + k]) ovf_q[k] <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_evt
        pmu_evt_sel #(.NUM_EVT(NUM_EVT)) u_sel (
            .code    (sel_q[g]),
            .strobes (evt_strobe),
            .trace   (trace_out),
            .hit     (hit[g])
        );

        pmu_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (reg_we && (reg_idx == 2'(IDX_EV0 + g))),
            .load_val (reg_wdata[CNT_W-1:0]),
            .clear    (wr_ctl && reg_wdata[CTL_EVRST]),
            .inc      (running && hit[g]),
            .cnt      (ev_cnt[g]),
            .wrap     (wrap[SRC_EV0 + g])
        );
    end

    pmu_counter #(.W(CNT_W)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reg_we && (reg_idx == IDX_CYC)),
        .load_val (reg_wdata[CNT_W-1:0]),
        .clear    (wr_ctl && reg_wdata[CTL_CYRST]),
        .inc      (cyc_tick),
        .cnt      (cyc_cnt),
        .wrap     (wrap[SRC_CYC])
    );

    always_comb begin
        ctl_view = '0;
        ctl_view[CTL_EN]                     = running;
        ctl_view[CTL_DIV]                    = div_sel;
        ctl_view[CTL_IE_LSB +: NUM_SRC]      = ie_q;
        ctl_view[CTL_OVF_LSB +: NUM_SRC]     = ovf_q;
        ctl_view[SEL1_LSB +: SEL_W]          = sel_q[1];
        ctl_view[SEL0_LSB +: SEL_W]          = sel_q[0];
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_idx)
            IDX_CTL: reg_rdata                = ctl_view;
            IDX_CYC: reg_rdata[CNT_W-1:0]     = cyc_cnt;
            IDX_EV0: reg_rdata[CNT_W-1:0]     = ev_cnt[0];
            IDX_EV1: reg_rdata[CNT_W-1:0]     = ev_cnt[1];
        endcase
    end

    assign irq = |(ovf_q & ie_q);

endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [1:0]       reg_idx,
    input logic [31:0]      reg_wdata,
    input logic             trace_out,
    input logic             irq,
    input logic             running,
    input logic [7:0]       sel0,
    input logic [2:0]       ovf_q,
    input logic [2:0]       wrap,
    input logic [CNT_W-1:0] cyc_cnt,
    input logic [CNT_W-1:0] ev0_cnt,
    input logic [CNT_W-1:0] ev1_cnt
);

    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(reg_we && (reg_idx == 2'd0 || reg_idx == 2'd1))) |=> $stable(cyc_cnt));

    assert_trace_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0 == 8'h20 && !trace_out && !(reg_we && (reg_idx == 2'd0 || reg_idx == 2'd2)))
        |=> $stable(ev0_cnt));

    assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == 2'd1) |=> (cyc_cnt == $past(reg_wdata[CNT_W-1:0])));

    assert_ev_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == 2'd0 && reg_wdata[1]) |=> (ev0_cnt == '0 && ev1_cnt == '0));

    assert_cyc_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[2] |=> (ovf_q[2] && cyc_cnt == '0));

    assert_ev0_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[0] |=> ovf_q[0]);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == 2'd0 && reg_wdata[10] && !wrap[2]) |=> !ovf_q[2]);

    assert_irq_has_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_q != 3'b000));

endmodule

bind perf_mon_unit pmu_checker #(.CNT_W(CNT_W)) u_pmu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .trace_out (trace_out),
    .irq       (irq),
    .running   (running),
    .sel0      (sel_q[0]),
    .ovf_q     (ovf_q),
    .wrap      (wrap),
    .cyc_cnt   (cyc_cnt),
    .ev0_cnt   (ev_cnt[0]),
    .ev1_cnt   (ev_cnt[1])
);

// File: tb/test_perf_mon_unit.sv
module test_perf_mon_unit;

    localparam int NUM_EVT = 32;
    localparam int WD_CYCLES = 20000;

    localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_IDLE = 3'd2, OP_STB = 3'd3, OP_IRQ = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  idx;
        logic [31:0] data;
        logic [31:0] exp;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 60;
    localparam vec_t VECS [NV] = '{
        '{OP_RD,   2'd0, 32'h0,        32'h0,        "R1"},
        '{OP_RD,   2'd1, 32'h0,        32'h0,        "R1"},
        '{OP_RD,   2'd2, 32'h0,        32'h0,        "R1"},
        '{OP_RD,   2'd3, 32'h0,        32'h0,        "R1"},
        '{OP_IRQ,  2'd0, 32'h0,        32'h0,        "R1"},
        '{OP_WR,   2'd0, 32'h1,        32'h0,        "R2"},
        '{OP_IDLE, 2'd0, 32'd9,        32'h0,        "R2"},
        '{OP_WR,   2'd0, 32'h0,        32'h0,        "R2"},
        '{OP_RD,   2'd1, 32'h0,        32'd10,       "R2"},
        '{OP_IDLE, 2'd0, 32'd5,        32'h0,        "R2"},
        '{OP_RD,   2'd1, 32'h0,        32'd10,       "R2"},
        '{OP_WR,   2'd1, 32'h12345678, 32'h0,        "R6"},
        '{OP_RD,   2'd1, 32'h0,        32'h12345678, "R6"},
        '{OP_WR,   2'd0, 32'h1,        32'h0,        "R6"},
        '{OP_WR,   2'd1, 32'h100,      32'h0,        "R6"},
        '{OP_WR,   2'd0, 32'h0,        32'h0,        "R6"},
        '{OP_RD,   2'd1, 32'h0,        32'h101,      "R6"},
        '{OP_WR,   2'd1, 32'h0,        32'h0,        "R3"},
        '{OP_WR,   2'd0, 32'h9,        32'h0,        "R3"},
        '{OP_IDLE, 2'd0, 32'd63,       32'h0,        "R3"},
        '{OP_RD,   2'd1, 32'h0,        32'h0,        "R3"},
        '{OP_IDLE, 2'd0, 32'd1,        32'h0,        "R3"},
        '{OP_RD,   2'd1, 32'h0,        32'h1,        "R3"},
        '{OP_WR,   2'd0, 32'h8,        32'h0,        "R3"},
        '{OP_RD,   2'd1, 32'h0,        32'h1,        "R3"},
        '{OP_RD,   2'd0, 32'h0,        32'h8,        "R3"},
        '{OP_STB,  2'd0, 32'hA,        32'h0,        "R4"},
        '{OP_WR,   2'd0, 32'h00302001, 32'h0,        "R4"},
        '{OP_IDLE, 2'd0, 32'd4,        32'h0,        "R4"},
        '{OP_STB,  2'd0, 32'h0,        32'h0,        "R4"},
        '{OP_IDLE, 2'd0, 32'd3,        32'h0,        "R4"},
        '{OP_WR,   2'd0, 32'h00302000, 32'h0,        "R4"},
        '{OP_RD,   2'd2, 32'h0,        32'd4,        "R4"},
        '{OP_RD,   2'd3, 32'h0,        32'd0,        "R4"},
        '{OP_RD,   2'd0, 32'h0,        32'h00302000, "R11"},
        '{OP_WR,   2'd2, 32'h0,        32'h0,        "R6"},
        '{OP_WR,   2'd3, 32'h0,        32'h0,        "R6"},
        '{OP_STB,  2'd0, 32'h0,        32'h1,        "R4"},
        '{OP_WR,   2'd0, 32'h0FF20001, 32'h0,        "R4"},
        '{OP_IDLE, 2'd0, 32'd5,        32'h0,        "R4"},
        '{OP_WR,   2'd0, 32'h0FF20000, 32'h0,        "R4"},
        '{OP_RD,   2'd2, 32'h0,        32'd6,        "R4"},
        '{OP_RD,   2'd3, 32'h0,        32'd6,        "R4"},
        '{OP_STB,  2'd0, 32'hFFFFFFFF, 32'h0,        "R5"},
        '{OP_WR,   2'd0, 32'h02040001, 32'h0,        "R5"},
        '{OP_IDLE, 2'd0, 32'd6,        32'h0,        "R5"},
        '{OP_WR,   2'd0, 32'h02040000, 32'h0,        "R5"},
        '{OP_RD,   2'd2, 32'h0,        32'd6,        "R5"},
        '{OP_RD,   2'd3, 32'h0,        32'd6,        "R4"},
        '{OP_STB,  2'd0, 32'h0,        32'h0,        "R7"},
        '{OP_WR,   2'd0, 32'h6,        32'h0,        "R7"},
        '{OP_RD,   2'd1, 32'h0,        32'h0,        "R7"},
        '{OP_RD,   2'd2, 32'h0,        32'h0,        "R7"},
        '{OP_RD,   2'd3, 32'h0,        32'h0,        "R7"},
        '{OP_RD,   2'd0, 32'h0,        32'h0,        "R7"},
        '{OP_WR,   2'd1, 32'h55,       32'h0,        "R7"},
        '{OP_WR,   2'd2, 32'h7,        32'h0,        "R7"},
        '{OP_WR,   2'd0, 32'h2,        32'h0,        "R7"},
        '{OP_RD,   2'd1, 32'h0,        32'h55,       "R7"},
        '{OP_RD,   2'd2, 32'h0,        32'h0,        "R7"}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_we = 1'b0;
    logic [1:0]         reg_idx = 2'd0;
    logic [31:0]        reg_wdata = 32'h0;
    logic [31:0]        reg_rdata;
    logic [NUM_EVT-1:0] evt_strobe = '0;
    logic               trace_out = 1'b0;
    logic               irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    perf_mon_unit i_perf_mon_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_idx    (reg_idx),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .evt_strobe (evt_strobe),
        .trace_out  (trace_out),
        .irq        (irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input logic [23:0] tag,
                       input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] idx, input logic [31:0] data);
        reg_we    = 1'b1;
        reg_idx   = idx;
        reg_wdata = data;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] idx, input logic [31:0] exp, input logic [23:0] tag);
        reg_idx = idx;
        #2;
        chk(reg_rdata, exp, tag, $sformatf("read idx %0d", idx));
    endtask

    task automatic do_irq(input logic exp, input logic [23:0] tag);
        #2;
        chk({31'b0, irq}, {31'b0, exp}, tag, "irq");
    endtask

    task automatic do_idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            case (v.op)
                OP_WR:   do_wr(v.idx, v.data);
                OP_RD:   do_rd(v.idx, v.exp, v.tag);
                OP_IDLE: do_idle(int'(v.data));
                OP_STB:  begin evt_strobe = v.data[NUM_EVT-1:0]; trace_out = v.exp[0]; end
                OP_IRQ:  do_irq(v.exp[0], v.tag);
                default: ;
            endcase
        end

        // R8 / R10: cycle counter wrap with its interrupt enabled
        do_wr(2'd1, 32'hFFFFFFFE);
        do_wr(2'd0, 32'h41);
        do_idle(1);
        do_irq(1'b0, "R10");
        do_rd(2'd0, 32'h41, "R11");
        do_idle(1);
        do_irq(1'b1, "R10");
        do_rd(2'd0, 32'h441, "R8");
        do_wr(2'd0, 32'h0);
        do_rd(2'd0, 32'h400, "R9");
        do_irq(1'b0, "R10");
        do_rd(2'd1, 32'h1, "R8");
        do_wr(2'd0, 32'h400);
        do_rd(2'd0, 32'h0, "R9");

        // R8 / R9: event counter 1 wrap, then write-back clears only its flag
        do_wr(2'd3, 32'hFFFFFFFF);
        evt_strobe = 32'h20;
        do_wr(2'd0, 32'h5021);
        do_idle(1);
        do_wr(2'd0, 32'h5020);
        do_rd(2'd0, 32'h5220, "R8");
        do_irq(1'b1, "R10");
        do_rd(2'd3, 32'h1, "R8");
        do_wr(2'd0, 32'h5220);
        do_rd(2'd0, 32'h5020, "R9");
        do_irq(1'b0, "R10");

        // R9: wrap on the same edge as a clearing write keeps the flag
        do_wr(2'd2, 32'hFFFFFFFF);
        do_wr(2'd0, 32'h00500001);
        do_wr(2'd0, 32'h00500101);
        do_wr(2'd0, 32'h00500000);
        do_rd(2'd0, 32'h00500100, "R9");

        // R6: event counter load beats a same-edge increment
        evt_strobe = 32'h2;
        do_wr(2'd0, 32'h00100001);
        do_wr(2'd2, 32'h40);
        do_wr(2'd0, 32'h0);
        do_rd(2'd2, 32'h41, "R6");
        evt_strobe = '0;

        // R1: reset in the middle of activity
        do_wr(2'd0, 32'h41);
        do_idle(3);
        rst_n = 1'b0;
        do_idle(2);
        rst_n = 1'b1;
        do_rd(2'd0, 32'h0, "R1");
        do_rd(2'd1, 32'h0, "R1");
        do_rd(2'd2, 32'h0, "R1");
        do_rd(2'd3, 32'h0, "R1");
        do_irq(1'b0, "R1");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule